// File: doc/BRIEF.md
# Dual-Button Press Capture Register

This block stores one data bit whenever an operator presses either of two active-low push buttons. Each button line is brought into the system clock domain by a short synchroniser chain. It then feeds a small three-state tracker that recognises the first clock of each press. The stored bit drives an indicator output. Holding a button down produces no further captures. Releasing it and pressing it again does capture again.

No clock is derived from the buttons. Every register runs on the system clock, and the capture enable is a one-cycle pulse produced by the trackers. A press from either button loads the register. Pressing both buttons in the same cycle still loads it only once.

Top module: `press_capture`

## Requirements
- R1: While `rst_ni` is low, and at once when it falls, `led_o` is 0, both trackers are idle and the synchroniser flops read "released" (1).
- R2: A button is pressed when its line is 0. Each line passes through two synchroniser flops. A press that is first sampled at rising edge k is captured at edge k+2, and `led_o` then takes the value `data_i` has at edge k+2.
- R3: Each tracker has three states: 0 (idle), 1 (first pressed cycle) and 2 (held). It moves 0→1 on a synchronised press and 1→2 while the press continues. It stays in 2 while held and returns to 0 from any state on release. Encoding 3 returns to 0.
- R4: While a button stays held after its capture, changes on `data_i` have no effect on `led_o`.
- R5: After a release that lasts at least one synchronised cycle, a new press captures again.
- R6: Either button alone triggers a capture. `btn_ni[0]` and `btn_ni[1]` behave identically.
- R7: Both buttons pressed in the same cycle produce one load. A second button pressed while the first is held produces its own capture.
- R8: A press lasting exactly one sampled clock still produces a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 2 | Push-button lines, active low |
| data_i | input | 1 | Bit to capture |
| led_o | output | 1 | Stored bit |

## Verification
The hardest situations to reach from the ports are those where the two trackers sit in different states at the same moment. Examples are one button held while the other starts a press, or both starting in the same cycle while `data_i` moves. A bench model built from the synchronised history of each line counts consecutive pressed cycles and predicts a load when any count starts. The sweep applies every sequence of four two-button patterns, with data bits that vary per step, so these overlaps arise systematically. Directed cases then pin the edge latency, single-cycle presses and hold behaviour with fixed expected cycle counts.

// File: rtl/press_capture_pkg.sv
package press_capture_pkg;
  localparam int unsigned TRK_W = 2;

  typedef enum logic [TRK_W-1:0] {
    TRK_IDLE  = 2'd0,
    TRK_FIRST = 2'd1,
    TRK_HELD  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/press_sync.sv
module press_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // reset to released level (lines are active low)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/press_tracker.sv
module press_tracker
  import press_capture_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pressed_i,
  output logic hit_o
);
  logic [TRK_W-1:0] st_q;
  logic [TRK_W-1:0] st_d;

  always_comb begin
    unique case (st_q)
      TRK_IDLE:  st_d = pressed_i ? TRK_FIRST : TRK_IDLE;
      TRK_FIRST: st_d = pressed_i ? TRK_HELD  : TRK_IDLE;
      TRK_HELD:  st_d = pressed_i ? TRK_HELD  : TRK_IDLE;
      default:   st_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TRK_IDLE;
    else         st_q <= st_d;
  end

  // capture on the edge that enters FIRST
  assign hit_o = (st_d == TRK_FIRST);

  // R3
  trk_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != 2'd3);

  // R4
  first_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TRK_FIRST) |=> (st_q != TRK_FIRST));

  // R5
  release_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pressed_i |=> (st_q == TRK_IDLE));
endmodule

// File: rtl/press_capture.sv
module press_capture #(
  parameter int unsigned NUM_BTN     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] btn_ni,
  input  logic               data_i,
  output logic               led_o
);
  logic [NUM_BTN-1:0] btn_sync;
  logic [NUM_BTN-1:0] hit;
  logic               load;
  logic               led_q;

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    press_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(btn_ni[g]),
      .sync_o (btn_sync[g])
    );

    press_tracker u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pressed_i(~btn_sync[g]),
      .hit_o    (hit[g])
    );
  end

  assign load = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   led_q <= 1'b0;
    else if (load) led_q <= data_i;
  end

  assign led_o = led_q;

  // R2
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (led_o == $past(data_i)));

  // R4
  hold_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(led_o));
endmodule

// File: tb/press_capture_bench.sv
module press_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] btn_n = 2'b11;
  logic       data = 1'b0;
  logic       led;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  press_capture u_press_capture (
    .clk_i (clk),
    .rst_ni(rst_n),
    .btn_ni(btn_n),
    .data_i(data),
    .led_o (led)
  );

  // reference: count consecutive synchronised pressed cycles per button
  logic [1:0] m_s1, m_s2;
  int         m_run [2];
  logic       m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 2'b11; m_s2 <= 2'b11; m_run[0] <= 0; m_run[1] <= 0; m_exp <= 1'b0;
    end else begin
      m_s1 <= btn_n;
      m_s2 <= m_s1;
      for (int i = 0; i < 2; i++)
        m_run[i] <= m_s2[i] ? 0 : ((m_run[i] < 2) ? m_run[i] + 1 : 2);
      if ((!m_s2[0] && m_run[0] == 0) || (!m_s2[1] && m_run[1] == 0)) m_exp <= data;
    end
  end

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: led_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", led, 1'b0);
    tick(2);
    check("R1", led, 1'b0);
    rst_n = 1'b1;
    tick(3);
    check("R1", led, 1'b0);

    // R2 latency: press sampled at edge k, captured at edge k+2
    data  = 1'b1;
    btn_n = 2'b10;
    tick(1); check("R2", led, 1'b0);
    tick(1); check("R2", led, 1'b0);
    tick(1); check("R2", led, 1'b1);

    // R4 hold: data toggles ignored
    for (int i = 0; i < 4; i++) begin
      data = i[0];
      tick(1);
      check("R4", led, 1'b1);
    end

    // R5 release then repress with data 0
    btn_n = 2'b11; tick(4);
    data = 1'b0; btn_n = 2'b10;
    tick(3); check("R5", led, 1'b0);
    btn_n = 2'b11; tick(4);

    // R6 second button alone
    data = 1'b1; btn_n = 2'b01;
    tick(2); check("R6", led, 1'b0);
    tick(1); check("R6", led, 1'b1);
    btn_n = 2'b11; tick(4);

    // R7 both at once: one load, data at that edge
    data = 1'b0; btn_n = 2'b00;
    tick(3); check("R7", led, 1'b0);
    data = 1'b1; tick(2); check("R7", led, 1'b0);
    // R7 staggered: release btn1, repress it while btn0 held
    btn_n = 2'b10; tick(4); check("R7", led, 1'b0);
    btn_n = 2'b00; tick(3); check("R7", led, 1'b1);
    btn_n = 2'b11; tick(4);

    // R8 single sampled cycle press
    data = 1'b0; btn_n = 2'b10;
    tick(1); btn_n = 2'b11;
    tick(2); check("R8", led, 1'b0);
    data = 1'b1; btn_n = 2'b01;
    tick(1); btn_n = 2'b11; data = 1'b0;
    tick(1); data = 1'b1;
    tick(1); check("R8", led, 1'b1);
    tick(4);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R1", led, 1'b0);
    tick(1); rst_n = 1'b1; tick(1);
    check("R1", led, 1'b0);

    // R3 sweep: all four-step two-button sequences against the model
    for (int s = 0; s < 256; s++) begin
      for (int st = 0; st < 4; st++) begin
        btn_n = 2'((s >> (2 * st)) & 3);
        data  = 1'(((s >> st) ^ (s >> (st + 3)) ^ st) & 1);
        tick(1);
        check("R3", led, m_exp);
      end
      btn_n = 2'b11;
      for (int st = 0; st < 4; st++) begin
        data = ~data;
        tick(1);
        check("R3", led, m_exp);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule